// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style core. Each cycle in which `op_valid` is high, it takes the working-register operand, a second operand and an operation code. The second operand is either a file-register value or an immediate literal. The block computes an 8-bit result and returns it one clock later on a registered output. The destination select travels alongside the result, so the writeback logic knows whether the value goes to the working register or to the file register.

The block also owns the five-bit status register. Each operation rewrites only the flags it affects and leaves the others as they were. The carry input of every carry- or borrow-consuming operation is the carry flag already held in that register. Subtraction is done as addition of the inverted operand. For subtractions, carry and digit carry therefore read as inverted borrows: 1 means no borrow occurred.

Instruction decode, operand fetch and the register-file write are outside this block.

Top module: `alu8_flags`

## Requirements
- R1: Op code 0 (add) produces W + F. It updates all five flags. Carry is the carry out of bit 7.
- R2: Op code 1 (add with carry) produces W + F + C, where C is the stored carry flag (status bit 0). It updates all five flags.
- R3: Op code 2 (subtract W from F) produces F - W. It updates all five flags. Carry is 1 exactly when no borrow occurred.
- R4: Op code 3 produces W - F - B, where the borrow B is the inverse of the stored carry flag. It updates all five flags.
- R5: Op code 4 produces F - W - B, with B the inverse of the stored carry flag. It updates all five flags.
- R6: Op code 5 treats F as a literal and produces F - W. It updates all five flags.
- R7: Digit carry (status bit 1) is the carry out of bit 3 for additions. For subtractions it is the inverted borrow out of bit 3.
- R8: Negative (status bit 4) equals result bit 7. Overflow (status bit 3) is set when the two's-complement result does not fit in 8 bits.
- R9: Zero (status bit 2) is set exactly when the 8-bit result is 0.
- R10: Op code 7 (AND) produces W & F. It updates only negative and zero, and leaves overflow, digit carry and carry unchanged.
- R11: Op code 6 (swap) exchanges the upper and lower nibbles of F. It changes no flag.
- R12: Result, destination select (0 = working register, 1 = file register) and `valid_out` appear one cycle after the accepted operation. When `op_valid` is low, or the op code is 8 to 15, result, destination and status hold their values and `valid_out` is low.
- R13: Synchronous reset clears the result, destination, valid output and status register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select |
| dest_in | input | 1 | Destination select for this operation |
| w_opnd | input | 8 | Working-register operand |
| f_opnd | input | 8 | File-register or literal operand |
| result | output | 8 | Registered result |
| dest_out | output | 1 | Registered destination select |
| status | output | 5 | Status register {N, OV, Z, DC, C} |
| valid_out | output | 1 | Result of a defined operation is present |

## Verification
Two things happen on the same clock edge: an add-with-carry or subtract-with-borrow reads the stored carry flag, and the status register is rewritten with the carry flag of that same operation. The bench issues a new operation on every cycle, and the operations are drawn from all codes in an interleaved order. As a result, each with-carry operation consumes the carry left by the one just before it, and AND and swap sit between them and must pass the earlier carry through untouched. A bench-side model keeps its own status word and recomputes every result and flag with plain integer arithmetic. Each registered output is compared with that model one cycle after the operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW   = 4;
  localparam int NFLAG = 5;

  // status bit positions
  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_SUBW   = 4'd2,
    OP_SUBFWB = 4'd3,
    OP_SUBWFB = 4'd4,
    OP_SUBL   = 4'd5,
    OP_SWAP   = 4'd6,
    OP_AND    = 4'd7
  } alu_op_e;

  typedef enum logic {SEL_ARITH = 1'b0, SEL_LOGIC = 1'b1} res_sel_e;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hcout,
  output logic         ovf
);
  localparam int HALF = W / 2;

  logic [W-1:0]  bb;
  logic [W:0]    full;
  logic [HALF:0] low;

  assign bb   = inv_b ? ~b : b;
  assign full = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, cin};
  assign low  = {1'b0, a[HALF-1:0]} + {1'b0, bb[HALF-1:0]} + {{HALF{1'b0}}, cin};

  assign sum   = full[W-1:0];
  assign cout  = full[W];
  assign hcout = low[HALF];
  assign ovf   = (a[W-1] == bb[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_swap,
  output logic [W-1:0] y
);
  localparam int HALF = W / 2;

  logic [W-1:0] swapped;

  genvar gi;
  generate
    for (gi = 0; gi < HALF; gi++) begin : g_nib
      assign swapped[gi]        = b[gi + HALF];
      assign swapped[gi + HALF] = b[gi];
    end
  endgenerate

  assign y = do_swap ? swapped : (a & b);
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NF-1:0] mask,
  input  logic [NF-1:0] next,
  output logic [NF-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= (q & ~mask) | (next & mask);
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OPW-1:0]   op_code,
  input  logic             dest_in,
  input  logic [W-1:0]     w_opnd,
  input  logic [W-1:0]     f_opnd,
  output logic [W-1:0]     result,
  output logic             dest_out,
  output logic [NFLAG-1:0] status,
  output logic             valid_out
);
  localparam logic [NFLAG-1:0] M_ALL = {NFLAG{1'b1}};
  localparam logic [NFLAG-1:0] M_NZ  = NFLAG'((1 << FLG_N) | (1 << FLG_Z));

  logic [W-1:0]     add_a, add_b, add_sum, log_y, res_d;
  logic             add_inv, add_cin, add_c, add_dc, add_ov;
  logic             is_def, do_swap;
  res_sel_e         sel;
  logic [NFLAG-1:0] fmask, fnext;
  logic             c_q;

  assign c_q = status[FLG_C];

  always_comb begin
    add_a   = w_opnd;
    add_b   = f_opnd;
    add_inv = 1'b0;
    add_cin = 1'b0;
    sel     = SEL_ARITH;
    do_swap = 1'b0;
    fmask   = M_ALL;
    is_def  = 1'b1;
    case (op_code)
      OP_ADD:    ;
      OP_ADDC:   add_cin = c_q;
      OP_SUBW,
      OP_SUBL: begin
        add_a = f_opnd; add_b = w_opnd; add_inv = 1'b1; add_cin = 1'b1;
      end
      OP_SUBFWB: begin
        add_inv = 1'b1; add_cin = c_q;
      end
      OP_SUBWFB: begin
        add_a = f_opnd; add_b = w_opnd; add_inv = 1'b1; add_cin = c_q;
      end
      OP_SWAP: begin
        sel = SEL_LOGIC; do_swap = 1'b1; fmask = '0;
      end
      OP_AND: begin
        sel = SEL_LOGIC; fmask = M_NZ;
      end
      default: begin
        is_def = 1'b0; fmask = '0;
      end
    endcase
  end

  alu8_adder #(.W(W)) u_add (
    .a(add_a), .b(add_b), .inv_b(add_inv), .cin(add_cin),
    .sum(add_sum), .cout(add_c), .hcout(add_dc), .ovf(add_ov)
  );

  alu8_logic #(.W(W)) u_log (
    .a(w_opnd), .b(f_opnd), .do_swap(do_swap), .y(log_y)
  );

  assign res_d = (sel == SEL_LOGIC) ? log_y : add_sum;

  always_comb begin
    fnext         = '0;
    fnext[FLG_N]  = res_d[W-1];
    fnext[FLG_OV] = add_ov;
    fnext[FLG_Z]  = (res_d == '0);
    fnext[FLG_DC] = add_dc;
    fnext[FLG_C]  = add_c;
  end

  alu8_status #(.NF(NFLAG)) u_st (
    .clk(clk), .rst(rst), .load(op_valid && is_def),
    .mask(fmask), .next(fnext), .q(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      dest_out  <= 1'b0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= op_valid && is_def;
      if (op_valid && is_def) begin
        result   <= res_d;
        dest_out <= dest_in;
      end
    end
  end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [OPW-1:0]   op_code,
  input logic             dest_in,
  input logic [W-1:0]     w_opnd,
  input logic [W-1:0]     f_opnd,
  input logic [W-1:0]     result,
  input logic             dest_out,
  input logic [NFLAG-1:0] status,
  input logic             valid_out
);
  localparam int HALF = W / 2;

  // R13
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && result == '0 && !valid_out));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(result) && $stable(status) && !valid_out));

  // R12
  dest_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code < 4'd8) |=> (dest_out == $past(dest_in) && valid_out));

  // R11
  swap_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SWAP) |=>
      ($stable(status) && result == {$past(f_opnd[HALF-1:0]), $past(f_opnd[W-1:HALF])}));

  // R10
  and_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_AND) |=>
      ($stable(status[FLG_OV]) && $stable(status[FLG_DC]) && $stable(status[FLG_C])));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code < 4'd8 && op_code != OP_SWAP) |=> (status[FLG_Z] == (result == '0)));

  // R8
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code < 4'd8 && op_code != OP_SWAP) |=> (status[FLG_N] == result[W-1]));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADD && w_opnd[W-1] != f_opnd[W-1]) |=> !status[FLG_OV]);
endmodule

bind alu8_flags alu8_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .dest_in(dest_in), .w_opnd(w_opnd), .f_opnd(f_opnd), .result(result),
  .dest_out(dest_out), .status(status), .valid_out(valid_out)
);

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic       dest_in = 1'b0;
  logic [7:0] w_opnd = '0, f_opnd = '0;
  logic [7:0] result;
  logic       dest_out, valid_out;
  logic [4:0] status;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  logic [7:0] e_res = '0;
  logic       e_dest = 1'b0, e_vld = 1'b0;
  logic [4:0] e_st = '0;

  always #2 clk = ~clk;

  alu8_flags u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .dest_in(dest_in), .w_opnd(w_opnd), .f_opnd(f_opnd), .result(result),
    .dest_out(dest_out), .status(status), .valid_out(valid_out)
  );

  function automatic string tag(input int op);
    case (op)
      0: return "R1 R7 R8 R9";
      1: return "R2 R7 R8 R9";
      2: return "R3 R7 R8 R9";
      3: return "R4 R7 R8 R9";
      4: return "R5 R7 R8 R9";
      5: return "R6 R7 R8 R9";
      6: return "R11";
      7: return "R10 R9";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // independent reference: updates e_res/e_st/e_dest/e_vld for one op
  task automatic model(input bit v, input int op, input int w, input int f, input bit d);
    int a, b, ci, s, sa, sb, ss, r;
    bit c, dc, ov, arith;
    c = e_st[0];
    e_vld = v && op < 8;
    if (!e_vld) return;
    arith = 1'b1; r = 0; dc = 0; ov = 0; a = 0; b = 0; ci = 0;
    case (op)
      0: begin a = w; b = f; ci = 0; end
      1: begin a = w; b = f; ci = c; end
      2: begin a = f; b = w; ci = 0; end
      3: begin a = w; b = f; ci = !c; end
      4: begin a = f; b = w; ci = !c; end
      5: begin a = f; b = w; ci = 0; end
      default: arith = 1'b0;
    endcase
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (op <= 1) begin
      s = a + b + ci; r = s % 256; c = s > 255;
      dc = ((a % 16) + (b % 16) + ci) > 15;
      ss = sa + sb + ci; ov = (ss > 127) || (ss < -128);
    end else if (arith) begin
      s = a - b - ci; r = (s + 256) % 256; c = s >= 0;
      dc = ((a % 16) - (b % 16) - ci) >= 0;
      ss = sa - sb - ci; ov = (ss > 127) || (ss < -128);
    end
    e_dest = d;
    if (arith) begin
      e_res = r[7:0];
      e_st  = {r[7], ov, (r == 0), dc, c};
    end else if (op == 6) begin
      e_res = {f[3:0], f[7:4]};
    end else begin
      r = w & f;
      e_res = r[7:0];
      e_st[4] = r[7];
      e_st[2] = (r == 0);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "result", result, e_res);
    chk(req, "status", status, e_st);
    chk(req, "dest", dest_out, e_dest);
    chk(req, "valid", valid_out, e_vld);
  endtask

  // apply at negedge, check at the following negedge (one register stage)
  task automatic step(input bit v, input int op, input int w, input int f, input bit d);
    op_valid = v; op_code = op[3:0]; w_opnd = w[7:0]; f_opnd = f[7:0]; dest_in = d;
    model(v, op, w, f, d);
    @(negedge clk);
    compare(v ? tag(op) : "R12");
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13: reset state
    compare("R13");

    // directed corners
    step(1, 0, 8'h7F, 8'h01, 0);   // R8 positive overflow
    step(1, 0, 8'hFF, 8'h01, 1);   // R9 zero with carry, R7 digit carry
    step(1, 1, 8'h00, 8'h00, 0);   // R2 carry-in of 1 consumed
    step(1, 2, 8'h01, 8'h00, 1);   // R3 borrow -> C=0
    step(1, 3, 8'h00, 8'h00, 0);   // R4 borrow from C=0 -> 0xFF
    step(1, 7, 8'hF0, 8'h0F, 1);   // R10 zero, C/DC/OV kept
    step(1, 6, 8'h00, 8'hA5, 0);   // R11 flags kept
    step(1, 4, 8'h01, 8'h80, 1);   // R5 negative overflow
    step(1, 5, 8'h10, 8'h10, 0);   // R6 zero, no borrow
    step(1, 9, 8'h12, 8'h34, 1);   // R12 undefined code held
    step(0, 0, 8'h55, 8'h55, 1);   // R12 idle held

    // back-to-back sweep over mixed ops so carry chains between cycles
    for (int w = 0; w < 256; w += 3) begin
      for (int f = 0; f < 256; f++) begin
        step(1, (f * 7 + w) % 10, w, f, f[0] ^ w[1]);
      end
      step(0, 1, w, 0, 1);
    end

    // R13: reset mid-run clears a nonzero state
    step(1, 3, 8'h00, 8'h01, 1);
    rst = 1'b1; op_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    e_res = '0; e_st = '0; e_dest = 1'b0; e_vld = 1'b0;
    compare("R13");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule